// File: doc/BRIEF.md
# Five-Bit Symbol Line Encoder with NRZI Output

This block takes a stream of 4-bit nibbles and turns each one into a 5-bit line symbol. A flag beside each nibble marks it as an escape. The data nibbles have already been scrambled upstream. Each symbol is shifted onto a one-bit line output, one bit per clock, and the bit stream is NRZI coded before it leaves. The code table is a fixed set of seventeen symbols: sixteen for the data values and one for the escape.

The block pulls its input. Once every five clocks it raises a request strobe, and it samples the nibble inputs only in that cycle. If the upstream source has no nibble ready in that cycle, the block flags an underflow for the whole five-bit slot and holds the line level still. Framing, scrambling and the receive side are handled elsewhere.

Top module: `sym5_line_encoder`

## Requirements
- R1: While reset is asserted and directly after it, `lineOut` is 0, `underflow` is 0 and `nibReady` is 1.
- R2: `nibReady` is high in exactly one clock cycle out of every five, and it is never high in two consecutive cycles.
- R3: A data nibble accepted with `nibEscape`=0 is sent as the symbol: 0→01010, 1→01001, 2→10101, 3→01011, 4→01110, 5→01101, 6→00111, 7→01111, 8→11010, 9→11001, A→10010, B→11011, C→11110, D→11101, E→10111, F→11111.
- R4: A nibble accepted with `nibEscape`=1 is sent as the symbol 00010, whatever the value on `nibData`.
- R5: Symbol bits leave MSB first. The first bit takes effect on `lineOut` at the same clock edge that accepts the nibble, and each later bit takes effect one edge after the one before it.
- R6: The output is NRZI. A symbol bit of 1 inverts `lineOut` and a symbol bit of 0 leaves it unchanged.
- R7: If `nibValid` is 0 in a `nibReady` cycle, `underflow` reads 1 for the next five clocks and `lineOut` keeps its level over that whole slot.
- R8: The next nibble that is accepted clears `underflow` at its accepting edge. NRZI coding then resumes from the level that was held.
- R9: `nibValid` and the nibble inputs are ignored in any cycle where `nibReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nibValid | input | 1 | A nibble is offered |
| nibData | input | 4 | Nibble value (already scrambled) |
| nibEscape | input | 1 | Offered nibble is the escape |
| nibReady | output | 1 | Request strobe; the inputs are sampled in this cycle |
| lineOut | output | 1 | NRZI-coded serial line |
| underflow | output | 1 | The current slot had no nibble |

## Verification
The hardest case to reach from the ports is a nibble offered at the wrong moment. Stimulus has to hold `nibValid` high, with a nibble that would toggle the line, in the four cycles between requests, then drop it just before the request cycle. Only then does a held line and a raised underflow show that the stray offers were dropped. The bench also runs an escape and a starved slot back to back with data, which checks that NRZI carries its level correctly across a slot where nothing was sent.

// File: rtl/sym5_pkg.sv
package sym5_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam logic [SYM_W-1:0] ESC_SYM = 5'b00010;

  // Strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic load;   // slot boundary with a nibble offered
    logic starve; // slot boundary with nothing offered
    logic shift;  // inside a slot: advance one bit
  } sym5_ctrl_t;

  function automatic logic [SYM_W-1:0] dataSymbol(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] s;
    case (nib)
      4'h0: s = 5'b01010;  4'h1: s = 5'b01001;
      4'h2: s = 5'b10101;  4'h3: s = 5'b01011;
      4'h4: s = 5'b01110;  4'h5: s = 5'b01101;
      4'h6: s = 5'b00111;  4'h7: s = 5'b01111;
      4'h8: s = 5'b11010;  4'h9: s = 5'b11001;
      4'hA: s = 5'b10010;  4'hB: s = 5'b11011;
      4'hC: s = 5'b11110;  4'hD: s = 5'b11101;
      4'hE: s = 5'b10111;  default: s = 5'b11111;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sym5_ctrl.sv
module sym5_ctrl
  import sym5_pkg::*;
#(
  parameter int SLOT_LEN = SYM_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nibValid,
  output logic       nibReady,
  output sym5_ctrl_t ctrl
);
  localparam int CNT_W = $clog2(SLOT_LEN);

  logic [CNT_W-1:0] bitCnt;
  logic             slotStart;

  assign slotStart = (bitCnt == '0);
  assign nibReady  = slotStart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                bitCnt <= '0;
    else if (bitCnt == CNT_W'(SLOT_LEN - 1))   bitCnt <= '0;
    else                                       bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    ctrl.load   = slotStart &  nibValid;
    ctrl.starve = slotStart & ~nibValid;
    ctrl.shift  = ~slotStart;
  end

  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nibReady |=> !nibReady);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt < CNT_W'(SLOT_LEN));
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.load, ctrl.starve, ctrl.shift}));
endmodule

// File: rtl/sym5_datapath.sv
module sym5_datapath
  import sym5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sym5_ctrl_t       ctrl,
  input  logic [NIB_W-1:0] nibData,
  input  logic             nibEscape,
  output logic             lineOut,
  output logic             underflow
);
  logic [SYM_W-1:0] symbol;
  logic [SYM_W-1:0] shiftReg;
  logic             haveSym;
  logic             lineLevel;
  logic             underflowQ;

  assign symbol = nibEscape ? ESC_SYM : dataSymbol(nibData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      haveSym    <= 1'b0;
      lineLevel  <= 1'b0;
      underflowQ <= 1'b0;
    end else if (ctrl.load) begin
      shiftReg   <= {symbol[SYM_W-2:0], 1'b0};
      lineLevel  <= lineLevel ^ symbol[SYM_W-1];
      haveSym    <= 1'b1;
      underflowQ <= 1'b0;
    end else if (ctrl.starve) begin
      shiftReg   <= '0;
      haveSym    <= 1'b0;
      underflowQ <= 1'b1;
    end else if (ctrl.shift && haveSym) begin
      shiftReg   <= {shiftReg[SYM_W-2:0], 1'b0};
      lineLevel  <= lineLevel ^ shiftReg[SYM_W-1];
    end
  end

  assign lineOut   = lineLevel;
  assign underflow = underflowQ;

  assert_hold_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflowQ && !ctrl.load) |=> (lineLevel == $past(lineLevel)));
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.starve |=> underflowQ);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load |=> !underflowQ);
  assert_zero_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.shift && haveSym && !shiftReg[SYM_W-1]) |=> $stable(lineLevel));
  assert_esc_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.load && nibEscape) |=> $stable(lineLevel));
endmodule

// File: rtl/sym5_line_encoder.sv
module sym5_line_encoder
  import sym5_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nibValid,
  input  logic [3:0] nibData,
  input  logic       nibEscape,
  output logic       nibReady,
  output logic       lineOut,
  output logic       underflow
);
  sym5_ctrl_t ctrl;

  sym5_ctrl #(.SLOT_LEN(SYM_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .nibValid (nibValid),
    .nibReady (nibReady),
    .ctrl     (ctrl)
  );

  sym5_datapath u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .nibData   (nibData),
    .nibEscape (nibEscape),
    .lineOut   (lineOut),
    .underflow (underflow)
  );
endmodule

// File: tb/sym5_line_encoder_bench.sv
`timescale 1ns/1ps
module sym5_line_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nibValid = 1'b0;
  logic [3:0] nibData = 4'h0;
  logic       nibEscape = 1'b0;
  logic       nibReady, lineOut, underflow;

  int  nCompared = 0;
  int  nMismatch = 0;
  bit  refLevel  = 1'b0;
  bit  finished  = 1'b0;

  always #2.5 clk = ~clk;

  sym5_line_encoder u_sym5_line_encoder (
    .clk(clk), .rst_n(rst_n), .nibValid(nibValid), .nibData(nibData),
    .nibEscape(nibEscape), .nibReady(nibReady), .lineOut(lineOut),
    .underflow(underflow)
  );

  function automatic logic [4:0] expSym(input logic [3:0] n, input logic esc);
    logic [4:0] t [16] = '{5'b01010, 5'b01001, 5'b10101, 5'b01011,
                           5'b01110, 5'b01101, 5'b00111, 5'b01111,
                           5'b11010, 5'b11001, 5'b10010, 5'b11011,
                           5'b11110, 5'b11101, 5'b10111, 5'b11111};
    return esc ? 5'b00010 : t[n];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitReq();
    while (!nibReady) @(negedge clk);
  endtask

  // R3 R4 R5 R6: offer one nibble and follow the five NRZI bits
  task automatic sendNib(input logic [3:0] d, input logic esc, input string req);
    logic [4:0] s;
    waitReq();
    nibValid = 1'b1; nibData = d; nibEscape = esc;
    s = expSym(d, esc);
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk);
      if (i == 4) begin
        nibValid = 1'b0; nibData = ~d; nibEscape = ~esc;
        check({req, " R8 underflow"}, underflow, 0);
      end
      refLevel = refLevel ^ s[i];
      check({req, " R5 R6 bit"}, lineOut, refLevel);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 lineOut", lineOut, 0);
    check("R1 underflow", underflow, 0);
    check("R1 nibReady", nibReady, 1);
    rst_n = 1'b1;
    check("R1 nibReady after", nibReady, 1);
  endtask

  task automatic testAllData();
    for (int n = 0; n < 16; n++) sendNib(4'(n), 1'b0, "R3 data");
  endtask

  task automatic testEscape();
    sendNib(4'h5, 1'b1, "R4 escape");
    sendNib(4'hF, 1'b1, "R4 escape");
    sendNib(4'hA, 1'b0, "R3 after escape");
  endtask

  task automatic testPeriod();
    int pulses = 0;
    bit prev = 1'b0;
    waitReq();
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (nibReady) pulses++;
      if (nibReady && prev) check("R2 adjacent", 1, 0);
      prev = nibReady;
    end
    check("R2 pulses per 20", pulses, 4);
  endtask

  task automatic testUnderflow();
    waitReq();
    nibValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 flag", underflow, 1);
      check("R7 held", lineOut, refLevel);
    end
    sendNib(4'h2, 1'b0, "R8 resume");
  endtask

  // R9: offers outside the request cycle must not load anything
  task automatic testIgnore();
    waitReq();
    nibValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 held", lineOut, refLevel);
      nibData = 4'hF; nibEscape = 1'b0;
      nibValid = (i < 4) ? (nibReady ? 1'b0 : 1'b1) : 1'b0;
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 no load flag", underflow, 1);
      check("R9 no load line", lineOut, refLevel);
    end
    sendNib(4'hF, 1'b0, "R9 then data");
  endtask

  initial begin
    #500us;
    if (!finished) begin
      nCompared++; nMismatch++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    testReset();
    testPeriod();
    testAllData();
    testEscape();
    testUnderflow();
    testIgnore();
    testPeriod();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule